// File: doc/BRIEF.md
# Byte-Addressed Double-Buffered Control Register Bank

This block holds the control and status registers of a frame-based datapath behind a byte-wide access port with a 16-bit address. The serial protocol engine in front of it issues one byte read or one byte write per cycle. The registers behind the port are 8, 16 or 32 bits wide and naturally aligned. A multi-byte register is laid out big-endian: its lowest address carries its most significant byte.

Most timing-related registers are double-buffered. Port accesses reach a pending copy. A live copy feeds the downstream logic and reloads from pending only when `frame_start` pulses, so a frame never sees half of an update. Some bits are constant and ignore writes. One register is a sticky event register that software clears by writing ones. One register is decoded at a second address. One control bit can also be reached through its own single-bit address.

Top module: `frame_regbank`

## Requirements
- R1: After reset, reads return these defaults: ID 0x0754 at 0x3000; row window start 0x0000 at 0x3002; column window start 0x0000 at 0x3004; row window end 0x03BF at 0x3006; column window end 0x04FF at 0x3008; frame lines 0x03DE at 0x300A; line clocks 0x056C at 0x300C; control 0x10D8 at 0x3010; event flags 0x0000 at 0x3014; gain word 0x3F80_0000 at 0x3018. The live outputs and `ctrl_q` hold the same values.
- R2: A read of the byte at `acc_addr` is requested by `acc_rd`. The byte appears on `acc_rdata` with `acc_rvalid` high in the cycle after the request, and `acc_rvalid` is low in every other cycle, including the cycles during and just after reset.
- R3: A 16-bit register occupies an even address and the address above it. A 32-bit register occupies four addresses starting at a multiple of 4. In both cases the lowest address holds the most significant byte.
- R4: Addresses 0x3020 and 0x3021 reach the frame-lines register. Reads and writes there act exactly as at 0x300A and 0x300B.
- R5: Address 0x3100 is a single-bit view of control bit 2. A read returns 0x00 or 0x01. A write copies data bit 0 into control bit 2 and leaves all other control bits unchanged.
- R6: The window, frame-lines, line-clocks and gain registers are double-buffered. A write changes the value read back at once, but the live output keeps its old value until the cycle in which `frame_start` is high.
- R7: When `frame_start` is high in the same cycle as a write to a double-buffered register, the live output takes the value that includes that write.
- R8: Constant bits read 0 and ignore writes. These are line-clocks bit 0, control bits 14:13, row window bits 15:10, and column window bits 15:11.
- R9: Event flags bits 3:0 (the low byte at 0x3015) are set by the matching bits of `evt_set`. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A set and a clear of the same bit in the same cycle leave the bit set. The upper byte at 0x3014 reads 0x00 and ignores writes.
- R10: Addresses that map to no register read 0x00, and writes to them change nothing. Examples are 0x0000, 0x2000, 0x3012 and 0x4000.
- R11: The ID register at 0x3000–0x3001 is read-only and keeps 0x0754 after writes.
- R12: The control register is single-buffered. A write appears on `ctrl_q` one cycle later without any `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 16 | Byte address of the access |
| acc_wr | input | 1 | Write strobe for one byte |
| acc_wdata | input | 8 | Write data byte |
| acc_rd | input | 1 | Read request for one byte |
| acc_rdata | output | 8 | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | Read data valid, one cycle after acc_rd |
| frame_start | input | 1 | Commit pulse: pending copies load into live copies |
| evt_set | input | 4 | Sets the matching event flag bits |
| live_row_first | output | 16 | Live row window start |
| live_col_first | output | 16 | Live column window start |
| live_row_last | output | 16 | Live row window end |
| live_col_last | output | 16 | Live column window end |
| live_frame_lines | output | 16 | Live frame length in lines |
| live_line_clocks | output | 16 | Live line length in clocks |
| ctrl_q | output | 16 | Control register value |
| evt_flags | output | 4 | Sticky event flags |
| live_gain | output | 32 | Live gain word |

## Verification
The bench checks byte-lane order on both 16-bit and 32-bit registers. A design with swapped lanes would return 0x54 at 0x3000 and show a write to 0x301B in the top byte of the gain word. The bench also targets the same-cycle cases: a write together with `frame_start`, which a design committing the old pending value would miss, and a set together with a write-1 clear on an event bit, which a clear-priority design would drop. The single-bit alias is written with a byte whose other bits are ones, which catches a design that spills the whole byte into the control register. Constant bits, the read-only ID and unmapped addresses are all written with 0xFF and then read back, which exposes any storage left writable.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int ADDR_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 32;
  localparam int NREGS   = 10;
  localparam int IDX_W   = $clog2(NREGS);
  localparam int EVT_W   = 4;

  // register indices
  localparam int IDX_ID     = 0;
  localparam int IDX_ROW0   = 1;
  localparam int IDX_COL0   = 2;
  localparam int IDX_ROW1   = 3;
  localparam int IDX_COL1   = 4;
  localparam int IDX_LINES  = 5;
  localparam int IDX_LCLK   = 6;
  localparam int IDX_CTRL   = 7;
  localparam int IDX_EVT    = 8;
  localparam int IDX_GAIN   = 9;

  // second decode of a whole 16-bit register
  localparam logic [ADDR_W-1:0] ALIAS16_ADDR = 16'h3020;
  localparam int                ALIAS16_IDX  = IDX_LINES;

  // single-bit view of one control bit
  localparam logic [ADDR_W-1:0] BITV_ADDR = 16'h3100;
  localparam int                BITV_IDX  = IDX_CTRL;
  localparam int                BITV_POS  = 2;               // bit within register
  localparam int                BITV_NB   = 2;               // bytes of target register
  localparam int                BITV_LANE = BITV_NB - 1 - BITV_POS / BYTE_W;
  localparam int                BITV_BIT  = BITV_POS % BYTE_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [2:0]        nbytes;
    logic [WORD_W-1:0] rstv;
    logic [WORD_W-1:0] wmask;
    logic              dbuf;
    logic              w1c;
  } reg_desc_t;

  function automatic reg_desc_t reg_desc(input int i);
    reg_desc_t d;
    case (i)
      IDX_ID:    d = '{16'h3000, 3'd2, 32'h0000_0754, 32'h0000_0000, 1'b0, 1'b0};
      IDX_ROW0:  d = '{16'h3002, 3'd2, 32'h0000_0000, 32'h0000_03FF, 1'b1, 1'b0};
      IDX_COL0:  d = '{16'h3004, 3'd2, 32'h0000_0000, 32'h0000_07FF, 1'b1, 1'b0};
      IDX_ROW1:  d = '{16'h3006, 3'd2, 32'h0000_03BF, 32'h0000_03FF, 1'b1, 1'b0};
      IDX_COL1:  d = '{16'h3008, 3'd2, 32'h0000_04FF, 32'h0000_07FF, 1'b1, 1'b0};
      IDX_LINES: d = '{16'h300A, 3'd2, 32'h0000_03DE, 32'h0000_FFFF, 1'b1, 1'b0};
      IDX_LCLK:  d = '{16'h300C, 3'd2, 32'h0000_056C, 32'h0000_FFFE, 1'b1, 1'b0};
      IDX_CTRL:  d = '{16'h3010, 3'd2, 32'h0000_10D8, 32'h0000_9FFF, 1'b0, 1'b0};
      IDX_EVT:   d = '{16'h3014, 3'd2, 32'h0000_0000, 32'h0000_000F, 1'b0, 1'b1};
      default:   d = '{16'h3018, 3'd4, 32'h3F80_0000, 32'hFFFF_FFFF, 1'b1, 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [1:0]        lane,
  output logic              bit_view
);

  logic [NREGS-1:0]      match_vec;
  logic [NREGS-1:0][1:0] lane_vec;

  for (genvar g = 0; g < NREGS; g++) begin : g_match
    localparam reg_desc_t        D    = reg_desc(g);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(D.nbytes) - ADDR_W'(1);
    assign match_vec[g] = ((addr & ~SPAN) == D.addr);
    assign lane_vec[g]  = 2'(addr & SPAN);
  end

  always_comb begin
    hit      = 1'b0;
    idx      = '0;
    lane     = '0;
    bit_view = 1'b0;
    for (int i = 0; i < NREGS; i++) begin
      if (match_vec[i]) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        lane = lane_vec[i];
      end
    end
    if ({addr[ADDR_W-1:1], 1'b0} == ALIAS16_ADDR) begin
      hit  = 1'b1;
      idx  = IDX_W'(ALIAS16_IDX);
      lane = {1'b0, addr[0]};
    end
    if (addr == BITV_ADDR) begin
      hit      = 1'b1;
      bit_view = 1'b1;
      idx      = IDX_W'(BITV_IDX);
      lane     = 2'(BITV_LANE);
    end
  end

endmodule

// File: rtl/regbank_cell.sv
module regbank_cell #(
  parameter int          NB    = 2,
  parameter logic [31:0] RSTV  = 32'h0,
  parameter logic [31:0] WMASK = 32'hFFFF_FFFF,
  parameter bit          DBUF  = 1'b0,
  parameter bit          W1C   = 1'b0,
  localparam int         SW    = 8 * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [1:0]    lane,
  input  logic [7:0]    wr_byte,
  input  logic [7:0]    bit_en,
  input  logic [SW-1:0] set_bits,
  input  logic          commit,
  output logic [SW-1:0] pend_q,
  output logic [SW-1:0] live_q
);

  localparam logic [SW-1:0] WM = WMASK[SW-1:0];
  localparam logic [SW-1:0] RV = RSTV[SW-1:0];

  logic [SW-1:0] en_sh;
  logic [SW-1:0] dat_sh;
  logic [SW-1:0] pend_d;
  logic          pend_en;

  // byte steering: lane 0 is the most significant byte
  always_comb begin
    en_sh  = '0;
    dat_sh = '0;
    if (wr_stb && (int'(lane) < NB)) begin
      en_sh  = SW'(bit_en) << (8 * (NB - 1 - int'(lane)));
      dat_sh = SW'(wr_byte & bit_en) << (8 * (NB - 1 - int'(lane)));
    end
  end

  always_comb begin
    if (W1C) begin
      pend_d = (pend_q & ~(dat_sh & en_sh & WM)) | (set_bits & WM);
    end else begin
      pend_d = (pend_q & ~(en_sh & WM)) | (dat_sh & en_sh & WM);
    end
    pend_en = wr_stb | (|set_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= RV;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  if (DBUF) begin : g_live
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q <= RV;
      end else if (commit) begin
        live_q <= pend_d;
      end
    end
  end else begin : g_flow
    logic unused_commit;
    assign unused_commit = commit;
    assign live_q        = pend_q;
  end

endmodule

// File: rtl/regbank_rdsel.sv
module regbank_rdsel
  import regbank_pkg::*;
(
  input  logic                         hit,
  input  logic [IDX_W-1:0]             idx,
  input  logic [1:0]                   lane,
  input  logic                         bit_view,
  input  logic [NREGS-1:0][WORD_W-1:0] pend_all,
  output logic [BYTE_W-1:0]            rd_byte
);

  logic [NREGS-1:0][BYTE_W-1:0] byte_vec;

  for (genvar g = 0; g < NREGS; g++) begin : g_lane
    localparam reg_desc_t D  = reg_desc(g);
    localparam int        NB = int'(D.nbytes);
    assign byte_vec[g] = (int'(lane) < NB)
                       ? BYTE_W'(pend_all[g] >> (8 * (NB - 1 - int'(lane))))
                       : '0;
  end

  always_comb begin
    rd_byte = '0;
    if (bit_view) begin
      rd_byte = {7'b0, pend_all[BITV_IDX][BITV_POS]};
    end else if (hit) begin
      rd_byte = byte_vec[idx];
    end
  end

endmodule

// File: rtl/frame_regbank.sv
module frame_regbank
  import regbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] acc_addr,
  input  logic        acc_wr,
  input  logic [7:0]  acc_wdata,
  input  logic        acc_rd,
  output logic [7:0]  acc_rdata,
  output logic        acc_rvalid,
  input  logic        frame_start,
  input  logic [3:0]  evt_set,
  output logic [15:0] live_row_first,
  output logic [15:0] live_col_first,
  output logic [15:0] live_row_last,
  output logic [15:0] live_col_last,
  output logic [15:0] live_frame_lines,
  output logic [15:0] live_line_clocks,
  output logic [15:0] ctrl_q,
  output logic [3:0]  evt_flags,
  output logic [31:0] live_gain
);

  logic              dec_hit;
  logic [IDX_W-1:0]  dec_idx;
  logic [1:0]        dec_lane;
  logic              dec_bitv;
  logic [7:0]        w_byte;
  logic [7:0]        w_en;
  logic [7:0]        rd_byte;
  logic [7:0]        rdata_d;
  logic              rvalid_d;

  logic [NREGS-1:0][WORD_W-1:0] pend_all;
  logic [NREGS-1:0][WORD_W-1:0] live_all;

  regbank_decode u_dec (
    .addr     (acc_addr),
    .hit      (dec_hit),
    .idx      (dec_idx),
    .lane     (dec_lane),
    .bit_view (dec_bitv)
  );

  // single-bit view moves data bit 0 onto the aliased bit only
  always_comb begin
    if (dec_bitv) begin
      w_byte = {7'b0, acc_wdata[0]} << BITV_BIT;
      w_en   = 8'h01 << BITV_BIT;
    end else begin
      w_byte = acc_wdata;
      w_en   = 8'hFF;
    end
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam reg_desc_t D  = reg_desc(g);
    localparam int        NB = int'(D.nbytes);
    localparam int        SW = 8 * NB;

    logic [SW-1:0] p_w;
    logic [SW-1:0] l_w;
    logic [SW-1:0] s_w;
    logic          stb;

    assign stb = acc_wr && dec_hit && (dec_idx == IDX_W'(g));
    assign s_w = (g == IDX_EVT) ? SW'(evt_set) : '0;

    regbank_cell #(
      .NB    (NB),
      .RSTV  (D.rstv),
      .WMASK (D.wmask),
      .DBUF  (D.dbuf),
      .W1C   (D.w1c)
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (stb),
      .lane     (dec_lane),
      .wr_byte  (w_byte),
      .bit_en   (w_en),
      .set_bits (s_w),
      .commit   (frame_start),
      .pend_q   (p_w),
      .live_q   (l_w)
    );

    assign pend_all[g] = WORD_W'(p_w);
    assign live_all[g] = WORD_W'(l_w);
  end

  regbank_rdsel u_rd (
    .hit      (dec_hit),
    .idx      (dec_idx),
    .lane     (dec_lane),
    .bit_view (dec_bitv),
    .pend_all (pend_all),
    .rd_byte  (rd_byte)
  );

  // read response: next state then register
  always_comb begin
    rvalid_d = acc_rd;
    rdata_d  = acc_rd ? rd_byte : acc_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_rvalid <= 1'b0;
      acc_rdata  <= '0;
    end else begin
      acc_rvalid <= rvalid_d;
      acc_rdata  <= rdata_d;
    end
  end

  assign live_row_first   = live_all[IDX_ROW0][15:0];
  assign live_col_first   = live_all[IDX_COL0][15:0];
  assign live_row_last    = live_all[IDX_ROW1][15:0];
  assign live_col_last    = live_all[IDX_COL1][15:0];
  assign live_frame_lines = live_all[IDX_LINES][15:0];
  assign live_line_clocks = live_all[IDX_LCLK][15:0];
  assign ctrl_q           = live_all[IDX_CTRL][15:0];
  assign evt_flags        = live_all[IDX_EVT][EVT_W-1:0];
  assign live_gain        = live_all[IDX_GAIN];

  logic unused_live;
  assign unused_live = ^live_all;

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_rd,
  input logic        acc_rvalid,
  input logic        frame_start,
  input logic [3:0]  evt_set,
  input logic [15:0] live_frame_lines,
  input logic [15:0] live_line_clocks,
  input logic [15:0] live_row_last,
  input logic [15:0] ctrl_q,
  input logic [3:0]  evt_flags,
  input logic [31:0] live_gain
);

  // R2
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> acc_rvalid);

  // R2
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> !acc_rvalid);

  // R6
  lines_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(live_frame_lines));

  // R6
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(live_gain));

  // R8
  lclk_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_line_clocks[0] == 1'b0);

  // R8
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[14:13] == 2'b00);

  // R8
  row_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_row_last[15:10] == 6'd0);

  // R9
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((evt_flags & $past(evt_set)) == $past(evt_set)));

endmodule

bind frame_regbank regbank_chk u_regbank_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .acc_rd           (acc_rd),
  .acc_rvalid       (acc_rvalid),
  .frame_start      (frame_start),
  .evt_set          (evt_set),
  .live_frame_lines (live_frame_lines),
  .live_line_clocks (live_line_clocks),
  .live_row_last    (live_row_last),
  .ctrl_q           (ctrl_q),
  .evt_flags        (evt_flags),
  .live_gain        (live_gain)
);

// File: tb/frame_regbank_test.sv
module frame_regbank_test;

  logic        clk;
  logic        rst_n;
  logic [15:0] acc_addr;
  logic        acc_wr;
  logic [7:0]  acc_wdata;
  logic        acc_rd;
  logic [7:0]  acc_rdata;
  logic        acc_rvalid;
  logic        frame_start;
  logic [3:0]  evt_set;
  logic [15:0] live_row_first, live_col_first, live_row_last, live_col_last;
  logic [15:0] live_frame_lines, live_line_clocks, ctrl_q;
  logic [3:0]  evt_flags;
  logic [31:0] live_gain;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  frame_regbank uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d,
                    input logic fs = 1'b0, input logic [3:0] ev = 4'h0);
    @(negedge clk);
    acc_addr = a; acc_wdata = d; acc_wr = 1'b1; frame_start = fs; evt_set = ev;
    @(negedge clk);
    acc_wr = 1'b0; frame_start = 1'b0; evt_set = 4'h0;
  endtask

  task automatic pulse();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // driver: request a read and queue the expected byte
  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    acc_addr = a; acc_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    acc_rd = 1'b0;
  endtask

  // monitor: pop and compare each returned byte
  always @(negedge clk) begin
    if (rst_n && acc_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected rvalid actual=%h expected=none", acc_rdata);
      end else begin
        chk(tag_q.pop_front(), {24'h0, acc_rdata}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; acc_addr = '0; acc_wr = 1'b0; acc_wdata = '0; acc_rd = 1'b0;
    frame_start = 1'b0; evt_set = '0;
    repeat (3) @(negedge clk);
    chk("R2 rvalid in reset", {31'h0, acc_rvalid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 rvalid after reset", {31'h0, acc_rvalid}, 32'h0);
    chk("R1 live frame lines", {16'h0, live_frame_lines}, 32'h03DE);
    chk("R1 live line clocks", {16'h0, live_line_clocks}, 32'h056C);
    chk("R1 live row end", {16'h0, live_row_last}, 32'h03BF);
    chk("R1 live col end", {16'h0, live_col_last}, 32'h04FF);
    chk("R1 live row start", {16'h0, live_row_first}, 32'h0);
    chk("R1 live col start", {16'h0, live_col_first}, 32'h0);
    chk("R1 ctrl", {16'h0, ctrl_q}, 32'h10D8);
    chk("R1 gain", live_gain, 32'h3F80_0000);
    chk("R1 evt", {28'h0, evt_flags}, 32'h0);

    // R1 R2 R3 byte order
    rd(16'h3000, 8'h07, "R1 R2 id msb");
    rd(16'h3001, 8'h54, "R1 R2 id lsb");
    rd(16'h3008, 8'h04, "R1 col end msb");
    rd(16'h3009, 8'hFF, "R1 col end lsb");
    rd(16'h300C, 8'h05, "R1 lclk msb");
    rd(16'h300D, 8'h6C, "R1 lclk lsb");
    rd(16'h3018, 8'h3F, "R3 gain byte0");
    rd(16'h3019, 8'h80, "R3 gain byte1");
    rd(16'h301A, 8'h00, "R3 gain byte2");
    rd(16'h301B, 8'h00, "R3 gain byte3");

    // R10 unmapped
    rd(16'h2000, 8'h00, "R10 read 0x2000");
    rd(16'h4000, 8'h00, "R10 read 0x4000");
    wr(16'h3012, 8'hFF);
    rd(16'h3012, 8'h00, "R10 write 0x3012 ignored");
    wr(16'h0000, 8'hFF);
    rd(16'h0000, 8'h00, "R10 read 0x0000");

    // R11 read-only
    wr(16'h3000, 8'hAA);
    wr(16'h3001, 8'hAA);
    rd(16'h3000, 8'h07, "R11 id msb kept");
    rd(16'h3001, 8'h54, "R11 id lsb kept");

    // R6 pending vs live
    wr(16'h300A, 8'h12);
    wr(16'h300B, 8'h34);
    rd(16'h300A, 8'h12, "R6 pending msb");
    chk("R6 live lines held", {16'h0, live_frame_lines}, 32'h03DE);
    wr(16'h3008, 8'hFA);
    chk("R6 live col end held", {16'h0, live_col_last}, 32'h04FF);
    pulse();
    chk("R6 live lines committed", {16'h0, live_frame_lines}, 32'h1234);
    chk("R6 R8 live col end committed", {16'h0, live_col_last}, 32'h02FF);

    // R4 register alias
    rd(16'h3020, 8'h12, "R4 alias msb");
    rd(16'h3021, 8'h34, "R4 alias lsb");
    wr(16'h3021, 8'h56);
    rd(16'h300B, 8'h56, "R4 write via alias");

    // R8 constant bits
    wr(16'h300D, 8'hFF);
    rd(16'h300D, 8'hFE, "R8 lclk bit0");
    wr(16'h3002, 8'hFF);
    rd(16'h3002, 8'h03, "R8 row start upper bits");

    // R12 single-buffered control
    wr(16'h3010, 8'hFF);
    chk("R12 R8 ctrl direct", {16'h0, ctrl_q}, 32'h9FD8);
    rd(16'h3010, 8'h9F, "R8 ctrl msb");

    // R5 bit view
    rd(16'h3100, 8'h00, "R5 bit view clear");
    wr(16'h3100, 8'h01);
    chk("R5 bit view set", {16'h0, ctrl_q}, 32'h9FDC);
    rd(16'h3011, 8'hDC, "R5 ctrl lsb via word");
    wr(16'h3011, 8'h00);
    wr(16'h3100, 8'hFF);
    chk("R5 only bit2 written", {16'h0, ctrl_q}, 32'h9F04);
    rd(16'h3100, 8'h01, "R5 bit view read");
    wr(16'h3100, 8'hFE);
    chk("R5 bit view clear", {16'h0, ctrl_q}, 32'h9F00);

    // R7 same-cycle commit, R3 32-bit lanes
    wr(16'h3019, 8'h55, 1'b1);
    chk("R7 same-cycle commit", live_gain, 32'h3F55_0000);
    wr(16'h301B, 8'h11);
    chk("R6 gain held", live_gain, 32'h3F55_0000);
    rd(16'h301B, 8'h11, "R3 gain lsb pending");
    pulse();
    chk("R3 gain lsb lane", live_gain, 32'h3F55_0011);

    // R9 write-1-to-clear
    wr(16'h3015, 8'h00, 1'b0, 4'b0101);
    chk("R9 set", {28'h0, evt_flags}, 32'h5);
    rd(16'h3015, 8'h05, "R9 read flags");
    wr(16'h3015, 8'h04);
    rd(16'h3015, 8'h01, "R9 clear bit2");
    wr(16'h3015, 8'h00);
    rd(16'h3015, 8'h01, "R9 zero no effect");
    wr(16'h3014, 8'hFF);
    rd(16'h3014, 8'h00, "R9 upper byte");
    wr(16'h3015, 8'h01, 1'b0, 4'b0001);
    chk("R9 set wins", {28'h0, evt_flags}, 32'h1);
    wr(16'h3015, 8'h01);
    chk("R9 cleared", {28'h0, evt_flags}, 32'h0);

    repeat (4) @(negedge clk);
    chk("R2 all reads answered", exp_q.size(), 32'h0);
    finish_run();
  end

endmodule